// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block resolves control transfers for a 32-bit pipeline with one architectural delay slot. For each instruction issued to it, it receives the instruction's address, the instruction word and the two source register values. For every control transfer it works out whether the transfer is taken and where it goes. It holds that decision while the next issued instruction, which is the delay-slot instruction, goes through. In the cycle after the delay-slot instruction is issued, it raises a one-cycle redirect with the target address. The PC register and the fetch stage sit outside the block. They act on the redirect.

Compare branches form their target from the delay-slot address (branch address plus 4) plus a word-scaled, sign-extended 16-bit offset. Region jumps keep the upper four bits of the delay-slot address and replace the rest with the 26-bit index followed by two zero bits. The call form also requests a write of the return address into register 31. A register jump takes its target from the first operand and flags a target that is not word aligned. A control transfer found in a delay slot is reported and otherwise has no effect.

Top module: `xfer_target_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `redir_vld`, `redir_misalign`, `link_we` and `slot_err` are all 0.
- R2: Opcode (bits 31..26) 000100 is taken when `rs_val` equals `rt_val`. Opcode 000101 is taken when they differ.
- R3: Opcode 000110 is taken when `rs_val` has bit 31 set or is zero. Opcode 000111 is taken only when bit 31 is clear and the value is nonzero. These two opcodes ignore `rt_val`.
- R4: The target of a compare branch is `issue_pc + 4` plus the 16-bit offset (bits 15..0), shifted left by 2 and sign-extended.
- R5: Opcodes 000010 and 000011 jump to {bits 31..28 of `issue_pc + 4`, index bits 25..0, 2'b00}. The target therefore lands in the next 256 MB region when the jump sits in the last word of a region.
- R6: Opcode 000011 raises `link_we` for exactly the cycle after it is issued, with `link_data` = `issue_pc + 8` and `link_idx` = 31.
- R7: A taken transfer raises `redir_vld` for one cycle. That cycle is the cycle after the next `issue_vld` cycle (the delay slot), however many idle cycles come in between. `redir_pc` carries the target in that cycle.
- R8: A control transfer issued as a delay-slot instruction raises `slot_err` for one cycle. It produces no redirect of its own, no link write and no new delay slot. The transfer that owns the slot is still applied.
- R9: Opcode 000000 with function (bits 5..0) 001000 always jumps to `rs_val`. `redir_misalign` is high together with its redirect when bits 1..0 of `rs_val` are not both zero.
- R10: A transfer that is not taken still claims the next issued instruction as its delay slot and produces no redirect. A control transfer issued right after that slot is treated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| issue_pc | input | AW | Address of the issued instruction |
| issue_instr | input | 32 | Issued instruction word |
| rs_val | input | DW | Value of the first source register |
| rt_val | input | DW | Value of the second source register |
| redir_vld | output | 1 | Redirect the PC to `redir_pc` now |
| redir_pc | output | AW | Redirect target |
| redir_misalign | output | 1 | Redirect target is not word aligned (register jump) |
| link_we | output | 1 | Write the return address |
| link_idx | output | 5 | Register index of the return address write |
| link_data | output | AW | Return address |
| slot_err | output | 1 | A control transfer was found in a delay slot |

## Verification
The bench builds the unit with its defaults: 32-bit addresses and operands, and link register 31. This width puts the four region bits at 31..28, so a jump from address 0x0FFFFFFC can cross into the next region. It also lets signed-compare corner values such as 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF reach the zero and sign tests directly. The PC trace follows every redirect. Random streams therefore mix issue gaps, backward offsets, misaligned register targets and transfers placed in delay slots.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int OFF_W   = 16;
    localparam int IDX_W   = 26;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JMP     = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_CALL    = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_CMP_EQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_CMP_NE  = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_LE_Z    = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_GT_Z    = 6'b000111;
    localparam logic [FN_W-1:0]  FN_JREG     = 6'b001000;

    typedef enum logic [2:0] {
        XK_NONE,
        XK_CMP_EQ,
        XK_CMP_NE,
        XK_LE_Z,
        XK_GT_Z,
        XK_JMP,
        XK_CALL,
        XK_JREG
    } xfer_kind_e;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import xfer_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [FN_W-1:0]  fn,
    output xfer_kind_e       kind,
    output logic             is_xfer
);

    always_comb begin
        kind = XK_NONE;
        unique case (opc)
            OPC_CMP_EQ:  kind = XK_CMP_EQ;
            OPC_CMP_NE:  kind = XK_CMP_NE;
            OPC_LE_Z:    kind = XK_LE_Z;
            OPC_GT_Z:    kind = XK_GT_Z;
            OPC_JMP:     kind = XK_JMP;
            OPC_CALL:    kind = XK_CALL;
            OPC_SPECIAL: kind = (fn == FN_JREG) ? XK_JREG : XK_NONE;
            default:     kind = XK_NONE;
        endcase
    end

    assign is_xfer = (kind != XK_NONE);

endmodule

// File: rtl/xfer_cond.sv
module xfer_cond
    import xfer_pkg::*;
#(
    parameter int DW = 32
) (
    input  xfer_kind_e     kind,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    output logic           taken
);

    logic same;
    logic a_zero;
    logic a_neg;

    assign same   = (op_a == op_b);
    assign a_zero = ~|op_a;
    assign a_neg  = op_a[DW-1];

    always_comb begin
        unique case (kind)
            XK_CMP_EQ: taken = same;
            XK_CMP_NE: taken = ~same;
            XK_LE_Z:   taken = a_neg | a_zero;
            XK_GT_Z:   taken = ~a_neg & ~a_zero;
            XK_JMP,
            XK_CALL,
            XK_JREG:   taken = 1'b1;
            default:   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/xfer_target.sv
module xfer_target
    import xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  xfer_kind_e        kind,
    input  logic [AW-1:0]     pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IDX_W-1:0]  index,
    input  logic [DW-1:0]     op_a,
    output logic [AW-1:0]     target,
    output logic              misalign,
    output logic [AW-1:0]     link_addr
);

    localparam int REGION_LSB = IDX_W + 2;
    localparam int SEXT_W     = AW - OFF_W - 2;

    logic [AW-1:0] slot_pc;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] region_tgt;
    logic [AW-1:0] reg_tgt;

    assign slot_pc   = pc + AW'(4);
    assign link_addr = pc + AW'(8);
    assign rel_tgt   = slot_pc + {{SEXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    assign reg_tgt   = op_a[AW-1:0];

    generate
        if (AW > REGION_LSB) begin : g_region
            assign region_tgt = {slot_pc[AW-1:REGION_LSB], index, 2'b00};
        end else begin : g_flat
            assign region_tgt = AW'({index, 2'b00});
        end
    endgenerate

    always_comb begin
        unique case (kind)
            XK_JMP,
            XK_CALL: target = region_tgt;
            XK_JREG: target = reg_tgt;
            default: target = rel_tgt;
        endcase
    end

    assign misalign = (kind == XK_JREG) && (|op_a[1:0]);

endmodule

// File: rtl/xfer_target_unit.sv
module xfer_target_unit
    import xfer_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int LINK_REG = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_vld,
    input  logic [AW-1:0]      issue_pc,
    input  logic [INSTR_W-1:0] issue_instr,
    input  logic [DW-1:0]      rs_val,
    input  logic [DW-1:0]      rt_val,
    output logic               redir_vld,
    output logic [AW-1:0]      redir_pc,
    output logic               redir_misalign,
    output logic               link_we,
    output logic [4:0]         link_idx,
    output logic [AW-1:0]      link_data,
    output logic               slot_err
);

    typedef struct packed {
        logic          in_slot;
        logic          pend;
        logic [AW-1:0] pend_tgt;
        logic          pend_mis;
        logic          redir_vld;
        logic [AW-1:0] redir_pc;
        logic          redir_mis;
        logic          link_we;
        logic [AW-1:0] link_data;
        logic          slot_err;
    } unit_state_t;

    unit_state_t st_d, st_q;

    xfer_kind_e    kind;
    logic          is_xfer;
    logic          taken;
    logic [AW-1:0] tgt;
    logic          tgt_mis;
    logic [AW-1:0] ret_addr;

    xfer_decode i_decode (
        .opc     (issue_instr[INSTR_W-1 -: OPC_W]),
        .fn      (issue_instr[FN_W-1:0]),
        .kind    (kind),
        .is_xfer (is_xfer)
    );

    xfer_cond #(.DW(DW)) i_cond (
        .kind  (kind),
        .op_a  (rs_val),
        .op_b  (rt_val),
        .taken (taken)
    );

    xfer_target #(.AW(AW), .DW(DW)) i_target (
        .kind      (kind),
        .pc        (issue_pc),
        .offset    (issue_instr[OFF_W-1:0]),
        .index     (issue_instr[IDX_W-1:0]),
        .op_a      (rs_val),
        .target    (tgt),
        .misalign  (tgt_mis),
        .link_addr (ret_addr)
    );

    // next-state: a held decision is released by the next issued instruction
    always_comb begin
        st_d           = st_q;
        st_d.redir_vld = 1'b0;
        st_d.redir_mis = 1'b0;
        st_d.link_we   = 1'b0;
        st_d.slot_err  = 1'b0;
        if (issue_vld) begin
            if (st_q.in_slot) begin
                st_d.in_slot = 1'b0;
                st_d.pend    = 1'b0;
                if (st_q.pend) begin
                    st_d.redir_vld = 1'b1;
                    st_d.redir_pc  = st_q.pend_tgt;
                    st_d.redir_mis = st_q.pend_mis;
                end
                if (is_xfer) begin
                    st_d.slot_err = 1'b1;
                end
            end else if (is_xfer) begin
                st_d.in_slot  = 1'b1;
                st_d.pend     = taken;
                st_d.pend_tgt = tgt;
                st_d.pend_mis = tgt_mis;
                if (kind == XK_CALL) begin
                    st_d.link_we   = 1'b1;
                    st_d.link_data = ret_addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_vld      = st_q.redir_vld;
    assign redir_pc       = st_q.redir_pc;
    assign redir_misalign = st_q.redir_mis;
    assign link_we        = st_q.link_we;
    assign link_idx       = 5'(LINK_REG);
    assign link_data      = st_q.link_data;
    assign slot_err       = st_q.slot_err;

endmodule

// File: rtl/xfer_target_unit_chk.sv
module xfer_target_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic issue_vld,
    input logic redir_vld,
    input logic redir_misalign,
    input logic link_we,
    input logic slot_err
);

    AST_LINK_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> $past(issue_vld)); // R6

    AST_LINK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> !link_we); // R6

    AST_REDIR_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> $past(issue_vld)); // R7

    AST_REDIR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |=> !redir_vld); // R7

    AST_MISALIGN_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        redir_misalign |-> redir_vld); // R9

    AST_SLOT_ERR_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> $past(issue_vld)); // R8

    AST_SLOT_ERR_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> !link_we); // R8

endmodule

bind xfer_target_unit xfer_target_unit_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_vld      (issue_vld),
    .redir_vld      (redir_vld),
    .redir_misalign (redir_misalign),
    .link_we        (link_we),
    .slot_err       (slot_err)
);

// File: tb/test_xfer_target_unit.sv
`timescale 1ns/1ps
module test_xfer_target_unit;

    localparam real HALF = 2.5;
    localparam int  MAX_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_vld;
    logic [31:0] issue_pc;
    logic [31:0] issue_instr;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic        redir_vld;
    logic [31:0] redir_pc;
    logic        redir_misalign;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic        slot_err;

    always #(HALF) clk = ~clk;

    xfer_target_unit i_xfer_target_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_vld      (issue_vld),
        .issue_pc       (issue_pc),
        .issue_instr    (issue_instr),
        .rs_val         (rs_val),
        .rt_val         (rt_val),
        .redir_vld      (redir_vld),
        .redir_pc       (redir_pc),
        .redir_misalign (redir_misalign),
        .link_we        (link_we),
        .link_idx       (link_idx),
        .link_data      (link_data),
        .slot_err       (slot_err)
    );

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    // reference model state
    logic        m_slot = 0, m_pend = 0, m_pmis = 0;
    logic [31:0] m_ptgt = 0;
    string       m_lbl = "R7";
    // expected outputs after the next edge
    logic        e_redir = 0, e_mis = 0, e_lwe = 0, e_err = 0;
    logic [31:0] e_rpc = 0, e_ldata = 0;
    string       e_lbl = "R7";
    logic [31:0] pc = 32'h0040_0000;

    localparam logic [31:0] NOP = 32'h0000_0000;
    localparam logic [31:0] ALU = 32'h0085_1020;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd4, 5'd5, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    function automatic logic [31:0] enc_jr();
        return {6'd0, 5'd4, 15'd0, 6'h08};
    endfunction

    // 0 none, 1 eq, 2 ne, 3 le0, 4 gt0, 5 jump, 6 call, 7 jump-reg
    function automatic int b_kind(input logic [31:0] ins);
        case (ins[31:26])
            6'h04: return 1;
            6'h05: return 2;
            6'h06: return 3;
            6'h07: return 4;
            6'h02: return 5;
            6'h03: return 6;
            6'h00: return (ins[5:0] == 6'h08) ? 7 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic b_taken(input int k, input logic [31:0] a, input logic [31:0] b);
        case (k)
            1: return a == b;
            2: return a != b;
            3: return $signed(a) <= 0;
            4: return $signed(a) > 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] b_target(input int k, input logic [31:0] p,
                                             input logic [31:0] ins, input logic [31:0] a);
        logic [31:0] off;
        off = 32'($signed(ins[15:0])) * 4;
        if (k == 7) return a;
        if (k == 5 || k == 6) return ((p + 4) & 32'hF000_0000) | (32'(ins[25:0]) << 2);
        return p + 4 + off;
    endfunction

    function automatic string b_label(input int k);
        case (k)
            1, 2: return "R2/R4 target";
            3, 4: return "R3/R4 target";
            5, 6: return "R5 target";
            default: return "R9 target";
        endcase
    endfunction

    task automatic check_outputs();
        check("R7 redirect flag", 32'(redir_vld), 32'(e_redir));
        if (e_redir) check(e_lbl, redir_pc, e_rpc);
        check("R9 misalign flag", 32'(redir_misalign), 32'(e_mis));
        check("R6 link enable", 32'(link_we), 32'(e_lwe));
        if (e_lwe) begin
            check("R6 link data", link_data, e_ldata);
            check("R6 link index", 32'(link_idx), 32'd31);
        end
        check("R8 slot error", 32'(slot_err), 32'(e_err));
    endtask

    task automatic model_step(input logic v, input logic [31:0] ins,
                              input logic [31:0] a, input logic [31:0] b);
        int k;
        k = b_kind(ins);
        e_redir = 0; e_mis = 0; e_lwe = 0; e_err = 0;
        if (v) begin
            if (m_slot) begin
                m_slot = 0;
                if (m_pend) begin
                    e_redir = 1; e_rpc = m_ptgt; e_mis = m_pmis; e_lbl = m_lbl;
                end
                m_pend = 0;
                if (k != 0) e_err = 1;
            end else if (k != 0) begin
                m_slot = 1;
                m_pend = b_taken(k, a, b);
                m_ptgt = b_target(k, pc, ins, a);
                m_pmis = (k == 7) && (a[1:0] != 2'b00);
                m_lbl  = b_label(k);
                if (k == 6) begin
                    e_lwe = 1; e_ldata = pc + 8;
                end
            end
            pc = e_redir ? {e_rpc[31:2], 2'b00} : pc + 4;
        end
    endtask

    task automatic cyc(input logic v, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        check_outputs();
        issue_vld   = v;
        issue_pc    = pc;
        issue_instr = ins;
        rs_val      = a;
        rt_val      = b;
        model_step(v, ins, a, b);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7FFF_FFFF;
            3: return 32'h0000_0001;
            4: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(2.0 * HALF * MAX_CYC);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; issue_vld = 0; issue_pc = 0; issue_instr = 0; rs_val = 0; rt_val = 0;
        // R1: flags low during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset redir", 32'(redir_vld), 0);
            check("R1 reset link", 32'(link_we), 0);
            check("R1 reset slot err", 32'(slot_err), 0);
            check("R1 reset misalign", 32'(redir_misalign), 0);
        end
        rst_n = 1;

        // R2 R4: equal compare taken, backward offset
        cyc(1, enc_i(6'h04, 16'hFFFE), 32'd5, 32'd5);
        cyc(1, NOP, 0, 0);
        // R2 R10: not-taken compare, then a transfer right after its slot
        cyc(1, enc_i(6'h05, 16'h0010), 32'd7, 32'd7);
        cyc(1, ALU, 0, 0);
        cyc(1, enc_i(6'h04, 16'h0020), 32'd1, 32'd2);
        cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h05, 16'h0003), 32'd1, 32'd2);
        cyc(1, NOP, 0, 0);
        // R7: idle gap before the delay slot
        cyc(1, enc_i(6'h07, 16'h0008), 32'd1, 0);
        cyc(0, NOP, 0, 0);
        cyc(0, NOP, 0, 0);
        cyc(1, NOP, 0, 0);
        cyc(1, NOP, 0, 0);
        // R3: zero and sign corners
        cyc(1, enc_i(6'h06, 16'h0004), 32'h0, 32'h1);          cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h06, 16'h0004), 32'h8000_0000, 0);      cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h06, 16'h0004), 32'h1, 0);              cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h07, 16'h0004), 32'h0, 0);              cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h07, 16'h0004), 32'h8000_0000, 0);      cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h07, 16'h0004), 32'h7FFF_FFFF, 0);      cyc(1, NOP, 0, 0);
        // R9 then R5: reach the last word of a region, jump across it
        cyc(1, enc_jr(), 32'h0FFF_FFF8, 0);
        cyc(1, NOP, 0, 0);
        cyc(1, enc_i(6'h04, 16'h0000), 0, 0);                  // slot at 0x0FFFFFFC
        cyc(1, NOP, 0, 0);
        cyc(1, enc_jr(), 32'h0FFF_FFF4, 0);
        cyc(1, NOP, 0, 0);
        cyc(1, NOP, 0, 0);                                     // at 0x0FFFFFF4
        cyc(1, NOP, 0, 0);                                     // at 0x0FFFFFF8
        cyc(1, enc_j(6'h02, 26'h10), 0, 0);                    // at 0x0FFFFFFC
        cyc(1, NOP, 0, 0);
        // R6: call links pc+8
        cyc(1, enc_j(6'h03, 26'h12345), 0, 0);
        cyc(1, NOP, 0, 0);
        // R9: misaligned register target
        cyc(1, enc_jr(), 32'h0040_0102, 0);
        cyc(1, NOP, 0, 0);
        // R8: call placed in the slot of a taken compare
        cyc(1, enc_i(6'h04, 16'h0004), 32'd3, 32'd3);
        cyc(1, enc_j(6'h03, 26'h55), 0, 0);
        cyc(1, NOP, 0, 0);
        cyc(1, NOP, 0, 0);

        // constrained random stream (all requirements R2..R10)
        for (int n = 0; n < 4000; n++) begin
            logic        v;
            logic [31:0] ins, a, b;
            v = ($urandom % 8) != 0;
            a = pick_val();
            b = ($urandom % 2) ? a : pick_val();
            case ($urandom % 10)
                0: ins = enc_i(6'h04, 16'($urandom));
                1: ins = enc_i(6'h05, 16'($urandom));
                2: ins = enc_i(6'h06, 16'($urandom));
                3: ins = enc_i(6'h07, 16'($urandom));
                4: ins = enc_j(6'h02, 26'($urandom));
                5: ins = enc_j(6'h03, 26'($urandom));
                6: begin
                    ins = enc_jr();
                    if (($urandom % 4) != 0) a = a & 32'hFFFF_FFFC;
                end
                default: ins = ALU;
            endcase
            cyc(v, ins, a, b);
        end
        cyc(0, NOP, 0, 0);
        cyc(0, NOP, 0, 0);
        @(negedge clk);
        check_outputs();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule